// File: doc/BRIEF.md
# Serial Receiver with Ninth-Bit Address Filter

This block receives asynchronous serial characters on a single line and hands them to a host through a small receive queue. Each frame has a low start bit, then eight or nine data bits sent least significant bit first, then a high stop bit. A strobe input gives the bit clock at sixteen times the bit rate. The receiver resynchronises the line and checks the start bit at its middle. It samples every data bit and the stop bit at their middles.

The host reads the oldest character, its ninth bit and its framing-error flag from the head of a two-entry queue, and pops that character with a one-cycle read strobe. Both flags are stored with each character, so they move forward with the character when it is read. No parity check is done in hardware: the ninth bit is passed to the host unchanged. In nine-bit mode an optional address filter drops every frame whose ninth bit is 0. This lets a node on a multidrop line wait for address characters only.

If a character arrives while the queue is full, the receiver raises a sticky overrun flag and stops receiving. The only way to clear that flag is to drop the receive-enable input.

Top module: `uarx_top`

## Requirements
- R1: After reset, dataValid and overrunErr are 0, and no character is delivered until a complete frame has been received.
- R2: While portEn is 0 the receiver ignores rxIn completely: no character is queued and no flag changes, whatever the line does.
- R3: While contEn is 0 no frame is received. Driving contEn to 0 also clears overrunErr on the next cycle.
- R4: A frame is a 0 start bit, then data bits least significant bit first, then a stop bit. With frame9 = 1 there are nine data bits and the ninth appears on rdNinth. With frame9 = 0 there are eight data bits and rdNinth reads 0.
- R5: With addrEn = 1 and frame9 = 1, a frame whose ninth bit is 0 is discarded and the queue does not change. A frame whose ninth bit is 1 is queued. With frame9 = 0, addrEn has no effect.
- R6: The ninth bit is delivered exactly as received. Neither its value nor the parity of the character affects whether the character is accepted or which flags are set.
- R7: If the stop bit is sampled as 0, the character is still queued with rdFrameErr = 1. This flag belongs to that character only: after it is read, the next character shows its own flag.
- R8: The queue holds two characters and delivers them oldest first. Each rdStrobe with dataValid = 1 removes the head. An rdStrobe while the queue is empty has no effect.
- R9: If a third accepted frame completes while both entries are full and no read happens in that cycle, overrunErr is set and the frame is dropped. The queued characters are kept, and no further frame is received while overrunErr is 1.
- R10: Reading characters does not clear overrunErr. Only R3 clears it.
- R11: A low pulse on rxIn that is gone by the middle of the start bit is rejected. After a frame, or after reception is enabled, a new start bit is accepted only once the line has been seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxIn | input | 1 | Serial line, idle high |
| baudTick | input | 1 | One-cycle strobe at sixteen times the bit rate |
| portEn | input | 1 | Port enable; 0 disables the receiver |
| contEn | input | 1 | Receive enable; 0 stops reception and clears overrun |
| frame9 | input | 1 | 1 selects nine data bits, 0 selects eight |
| addrEn | input | 1 | Ninth-bit address filter enable (nine-bit mode only) |
| rdStrobe | input | 1 | Pops the head character |
| rdData | output | 8 | Head character data |
| rdNinth | output | 1 | Head character ninth bit |
| rdFrameErr | output | 1 | Head character framing-error flag |
| dataValid | output | 1 | Queue holds at least one character |
| overrunErr | output | 1 | Sticky overrun flag |

## Verification
The bench builds the block with its defaults: sixteen ticks per bit and a two-entry queue. With a depth of two, the overrun case needs only three back-to-back frames, so the bench can reach the point where reception halts with both entries held. It can also show that the held characters are read out intact after the halt. The bench drives baudTick once every three clocks, so each bit lasts 48 clocks. This leaves room to send a start-bit glitch a few ticks wide and show that it is rejected before the mid-bit check.

// File: rtl/uarx_pkg.sv
package uarx_pkg;
  localparam int DATA_BITS = 8;
  localparam int MAX_BITS  = DATA_BITS + 1;
  localparam int IDX_W     = $clog2(MAX_BITS);

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic             startFrame;
    logic             sampleBit;
    logic             bitVal;
    logic [IDX_W-1:0] bitIdx;
    logic             frameDone;
    logic             stopOk;
  } uarx_strobe_t;

  // One queued character with its own flags.
  typedef struct packed {
    logic                 ninth;
    logic                 ferr;
    logic [DATA_BITS-1:0] data;
  } uarx_char_t;
endpackage

// File: rtl/uarx_ctrl.sv
module uarx_ctrl
  import uarx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         rxIn,
  input  logic         baudTick,
  input  logic         portEn,
  input  logic         contEn,
  input  logic         frame9,
  input  logic         overrunErr,
  output uarx_strobe_t strb
);
  localparam int CNT_W = $clog2(OVS);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OVS - 1);

  typedef enum logic [2:0] {S_ARM, S_IDLE, S_START, S_DATA, S_STOP} state_t;

  state_t           state;
  logic [CNT_W-1:0] tickCnt;
  logic [IDX_W-1:0] bitIdx;
  logic             rxMeta, rxSync;
  logic             runEn;
  logic [IDX_W-1:0] lastIdx;

  assign runEn   = portEn && contEn && !overrunErr;
  assign lastIdx = frame9 ? IDX_W'(MAX_BITS - 1) : IDX_W'(DATA_BITS - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxSync <= 1'b1;
    end else begin
      rxMeta <= rxIn;
      rxSync <= rxMeta;
    end
  end

  always_comb begin
    strb           = '0;
    strb.bitVal    = rxSync;
    strb.bitIdx    = bitIdx;
    strb.stopOk    = rxSync;
    if (runEn && baudTick) begin
      case (state)
        S_IDLE:  strb.startFrame = !rxSync;
        S_DATA:  strb.sampleBit  = (tickCnt == FULL_LAST);
        S_STOP:  strb.frameDone  = (tickCnt == FULL_LAST);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_ARM;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else if (!runEn) begin
      state   <= S_ARM;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else begin
      case (state)
        S_ARM: if (rxSync) state <= S_IDLE;
        S_IDLE: begin
          if (strb.startFrame) begin
            state   <= S_START;
            tickCnt <= '0;
          end
        end
        S_START: begin
          if (baudTick) begin
            if (tickCnt == HALF_LAST) begin
              tickCnt <= '0;
              bitIdx  <= '0;
              state   <= rxSync ? S_ARM : S_DATA;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
        end
        S_DATA: begin
          if (baudTick) begin
            if (tickCnt == FULL_LAST) begin
              tickCnt <= '0;
              if (bitIdx == lastIdx) state <= S_STOP;
              else bitIdx <= bitIdx + 1'b1;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
        end
        S_STOP: begin
          if (baudTick) begin
            if (tickCnt == FULL_LAST) begin
              tickCnt <= '0;
              state   <= S_ARM;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
        end
        default: state <= S_ARM;
      endcase
    end
  end

  AST_PORT_OFF_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    !portEn |=> !strb.frameDone); // R2
  AST_HALT_ON_OVERRUN: assert property (@(posedge clk) disable iff (!rstN)
    overrunErr |=> !strb.startFrame); // R9
  AST_START_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    strb.frameDone |=> !strb.startFrame); // R11
endmodule

// File: rtl/uarx_dpath.sv
module uarx_dpath
  import uarx_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  uarx_strobe_t         strb,
  input  logic                 frame9,
  input  logic                 addrEn,
  input  logic                 contEn,
  input  logic                 rdStrobe,
  output logic [DATA_BITS-1:0] rdData,
  output logic                 rdNinth,
  output logic                 rdFrameErr,
  output logic                 dataValid,
  output logic                 overrunErr
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [MAX_BITS-1:0] shiftReg;
  uarx_char_t          slots [DEPTH];
  logic [PTR_W-1:0]    wrPtr, rdPtr;
  logic [CNT_W-1:0]    count;
  logic                accept, rdPop, push, isFull;
  uarx_char_t          newChar;

  function automatic logic [PTR_W-1:0] ptrNext(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strb.startFrame) begin
      shiftReg <= '0;
    end else if (strb.sampleBit) begin
      shiftReg[strb.bitIdx] <= strb.bitVal;
    end
  end

  assign isFull  = (count == FULL_CNT);
  assign rdPop   = rdStrobe && (count != '0);
  assign accept  = strb.frameDone && (!(addrEn && frame9) || shiftReg[MAX_BITS-1]);
  assign push    = accept && (!isFull || rdPop);
  assign newChar = '{ninth: frame9 && shiftReg[MAX_BITS-1],
                     ferr:  !strb.stopOk,
                     data:  shiftReg[DATA_BITS-1:0]};

  always_ff @(posedge clk) begin
    if (push) slots[wrPtr] <= newChar;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push)  wrPtr <= ptrNext(wrPtr);
      if (rdPop) rdPtr <= ptrNext(rdPtr);
      case ({push, rdPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) overrunErr <= 1'b0;
    else if (!contEn) overrunErr <= 1'b0;
    else if (accept && isFull && !rdPop) overrunErr <= 1'b1;
  end

  assign dataValid  = (count != '0);
  assign rdData     = dataValid ? slots[rdPtr].data  : '0;
  assign rdNinth    = dataValid ? slots[rdPtr].ninth : 1'b0;
  assign rdFrameErr = dataValid ? slots[rdPtr].ferr  : 1'b0;

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT); // R8
  AST_ADDR_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.frameDone && addrEn && frame9 && !shiftReg[MAX_BITS-1] && !rdStrobe)
      |=> $stable(count)); // R5
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rstN)
    (accept && isFull && !rdStrobe && contEn) |=> overrunErr); // R9
  AST_OVERRUN_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !contEn |=> !overrunErr); // R3
  AST_READ_KEEPS_OVR: assert property (@(posedge clk) disable iff (!rstN)
    (overrunErr && contEn) |=> overrunErr); // R10
endmodule

// File: rtl/uarx_top.sv
module uarx_top
  import uarx_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int DEPTH = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxIn,
  input  logic                 baudTick,
  input  logic                 portEn,
  input  logic                 contEn,
  input  logic                 frame9,
  input  logic                 addrEn,
  input  logic                 rdStrobe,
  output logic [DATA_BITS-1:0] rdData,
  output logic                 rdNinth,
  output logic                 rdFrameErr,
  output logic                 dataValid,
  output logic                 overrunErr
);
  uarx_strobe_t strb;

  uarx_ctrl #(.OVS(OVS)) ctrl_i (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .baudTick(baudTick),
    .portEn(portEn), .contEn(contEn), .frame9(frame9),
    .overrunErr(overrunErr), .strb(strb)
  );

  uarx_dpath #(.DEPTH(DEPTH)) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .frame9(frame9), .addrEn(addrEn),
    .contEn(contEn), .rdStrobe(rdStrobe), .rdData(rdData), .rdNinth(rdNinth),
    .rdFrameErr(rdFrameErr), .dataValid(dataValid), .overrunErr(overrunErr)
  );
endmodule

// File: tb/uarx_top_tb_top.sv
module uarx_top_tb_top;
  localparam int TDIV   = 3;
  localparam int BITCLK = 16 * TDIV;
  localparam int NVEC   = 7;

  // {frame9, addrEn, stop, data[8:0], expAccept, expFerr}
  localparam logic [13:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 1'b1, 9'h05A, 1'b1, 1'b0},
    {1'b0, 1'b1, 1'b1, 9'h0C3, 1'b1, 1'b0},
    {1'b1, 1'b0, 1'b1, 9'h0A5, 1'b1, 1'b0},
    {1'b1, 1'b0, 1'b1, 9'h1FF, 1'b1, 1'b0},
    {1'b1, 1'b1, 1'b1, 9'h033, 1'b0, 1'b0},
    {1'b1, 1'b1, 1'b1, 9'h181, 1'b1, 1'b0},
    {1'b0, 1'b0, 1'b0, 9'h000, 1'b1, 1'b1}
  };

  logic clk = 1'b0, rstN = 1'b0, rxIn = 1'b1, baudTick = 1'b0;
  logic portEn = 1'b1, contEn = 1'b1, frame9 = 1'b0, addrEn = 1'b0, rdStrobe = 1'b0;
  logic [7:0] rdData;
  logic rdNinth, rdFrameErr, dataValid, overrunErr;
  int nChecks = 0, nFails = 0, tickDiv = 0, cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    tickDiv  <= (tickDiv == TDIV - 1) ? 0 : tickDiv + 1;
    baudTick <= (tickDiv == TDIV - 1);
  end

  uarx_top dut_i (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .baudTick(baudTick), .portEn(portEn),
    .contEn(contEn), .frame9(frame9), .addrEn(addrEn), .rdStrobe(rdStrobe),
    .rdData(rdData), .rdNinth(rdNinth), .rdFrameErr(rdFrameErr),
    .dataValid(dataValid), .overrunErr(overrunErr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic sendFrame(input logic [8:0] d, input bit nine, input bit stopV);
    @(negedge clk) rxIn = 1'b0;
    repeat (BITCLK) @(negedge clk);
    for (int i = 0; i < (nine ? 9 : 8); i++) begin
      rxIn = d[i];
      repeat (BITCLK) @(negedge clk);
    end
    rxIn = stopV;
    repeat (BITCLK) @(negedge clk);
    rxIn = 1'b1;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic readOne();
    @(negedge clk) rdStrobe = 1'b1;
    @(negedge clk) rdStrobe = 1'b0;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected <150000", cycles);
      finishRun();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    chk(dataValid == 1'b0, "R1 dataValid after reset", dataValid, 0);
    chk(overrunErr == 1'b0, "R1 overrunErr after reset", overrunErr, 0);

    // Vector walk: R4, R5, R6, R7
    for (int v = 0; v < NVEC; v++) begin
      frame9 = VEC[v][13];
      addrEn = VEC[v][12];
      sendFrame(VEC[v][10:2], VEC[v][13], VEC[v][11]);
      chk(dataValid == VEC[v][1], $sformatf("R5 accept vec %0d", v), dataValid, VEC[v][1]);
      if (VEC[v][1]) begin
        chk(rdData == VEC[v][9:2], $sformatf("R4 data vec %0d", v), rdData, VEC[v][9:2]);
        chk(rdNinth == (VEC[v][13] & VEC[v][10]), $sformatf("R6 ninth vec %0d", v),
            rdNinth, VEC[v][13] & VEC[v][10]);
        chk(rdFrameErr == VEC[v][0], $sformatf("R7 ferr vec %0d", v), rdFrameErr, VEC[v][0]);
        readOne();
        chk(dataValid == 1'b0, $sformatf("R8 empty after read vec %0d", v), dataValid, 0);
      end
    end
    frame9 = 1'b0;
    addrEn = 1'b0;

    // R7: error flag moves with its character
    sendFrame(9'h011, 1'b0, 1'b0);
    sendFrame(9'h022, 1'b0, 1'b1);
    chk(rdFrameErr == 1'b1 && rdData == 8'h11, "R7 bad-stop head", {rdFrameErr, rdData}, 9'h111);
    readOne();
    chk(rdFrameErr == 1'b0 && rdData == 8'h22, "R7 next char clean", {rdFrameErr, rdData}, 9'h022);
    readOne();

    // R8: read on empty queue has no effect
    readOne();
    sendFrame(9'h03C, 1'b0, 1'b1);
    chk(dataValid == 1'b1 && rdData == 8'h3C, "R8 empty read ignored", rdData, 8'h3C);
    readOne();
    chk(dataValid == 1'b0, "R8 single pop", dataValid, 0);

    // R2: port disabled
    portEn = 1'b0;
    sendFrame(9'h0AA, 1'b0, 1'b1);
    chk(dataValid == 1'b0, "R2 port off ignores line", dataValid, 0);
    portEn = 1'b1;
    repeat (4) @(negedge clk);

    // R3: receive disabled
    contEn = 1'b0;
    sendFrame(9'h055, 1'b0, 1'b1);
    chk(dataValid == 1'b0, "R3 receive off", dataValid, 0);
    contEn = 1'b1;
    repeat (4) @(negedge clk);

    // R11: glitch shorter than half a bit
    @(negedge clk) rxIn = 1'b0;
    repeat (2 * TDIV) @(negedge clk);
    rxIn = 1'b1;
    repeat (3 * BITCLK) @(negedge clk);
    chk(dataValid == 1'b0, "R11 glitch rejected", dataValid, 0);

    // R8, R9, R10: fill, overrun, halt, drain
    sendFrame(9'h0A1, 1'b0, 1'b1);
    sendFrame(9'h0B2, 1'b0, 1'b1);
    chk(overrunErr == 1'b0, "R8 two entries fit", overrunErr, 0);
    sendFrame(9'h0C3, 1'b0, 1'b1);
    chk(overrunErr == 1'b1, "R9 overrun on third", overrunErr, 1);
    sendFrame(9'h0D4, 1'b0, 1'b1);
    chk(rdData == 8'hA1, "R8 oldest first", rdData, 8'hA1);
    readOne();
    chk(rdData == 8'hB2 && dataValid, "R9 second kept", rdData, 8'hB2);
    readOne();
    chk(dataValid == 1'b0, "R9 dropped and halted frames absent", dataValid, 0);
    chk(overrunErr == 1'b1, "R10 read keeps overrun", overrunErr, 1);
    sendFrame(9'h0E5, 1'b0, 1'b1);
    chk(dataValid == 1'b0, "R9 halted while overrun", dataValid, 0);
    @(negedge clk) contEn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(overrunErr == 1'b0, "R3 contEn low clears overrun", overrunErr, 0);
    contEn = 1'b1;
    repeat (4) @(negedge clk);
    sendFrame(9'h0F6, 1'b0, 1'b1);
    chk(dataValid && rdData == 8'hF6, "R9 resumes after clear", rdData, 8'hF6);
    readOne();

    done = 1'b1;
    finishRun();
  end
endmodule